// File: doc/BRIEF.md
# Hiccup fault controller for a synchronous buck

This block is the protection state machine of a synchronous buck converter. Five fault flags feed it: a high-side overcurrent flag, a low-side overcurrent flag, an overvoltage flag, an undervoltage flag and an overtemperature flag. The comparators behind them, and the thermal hysteresis, sit outside the block. A one-clock strobe marks the end of every switching cycle. From these inputs the block drives gate overrides for the power stage and a shutdown flag, and it sends a one-cycle restart request to the soft-start sequencer.

A high-side overcurrent cuts the high-side pulse short for the rest of the switching cycle. If this happens in enough consecutive cycles, the converter trips. A low-side overcurrent trips at once. Both trips, and a persistent undervoltage, lead to a hiccup: both switches stay off for a programmable time, then a restart is requested. Overvoltage holds the low side on until the output falls to the undervoltage level, then latches high impedance. Overtemperature overrides every other fault. Normal start-up resumes when the overtemperature flag clears. All times are parameters counted in clock cycles.

Top module: `buck_fault_ctrl`

## Requirements
- R1: After reset, and while no fault is present, shutdown, force_hiz, force_ls_on and restart_req are all 0.
- R2: In normal operation, a high-side overcurrent asserts force_ls_on in the same cycle. The signal stays on until the clock after the next cyc_stb.
- R3: A switching cycle counts as faulty when hs_oc was high at any point from the previous strobe up to and including its own strobe. A clean cycle resets the count to zero. When HS_LIMIT consecutive cycles are faulty, shutdown and force_hiz assert on the clock after the last strobe.
- R4: In normal operation or during the overvoltage discharge, ls_oc asserts force_hiz in the same cycle and clears force_ls_on. From normal operation, shutdown follows on the next clock and the hiccup starts.
- R5: A hiccup holds shutdown=1 and force_hiz=1 for exactly HICCUP_CYC cycles. restart_req then pulses for one cycle while the other outputs return to 0. If the fault is still present, the detection starts over and can trip again.
- R6: uv_flag trips a hiccup only when it is high on UV_FILT_CYC consecutive clocks in normal operation. A shorter excursion has no effect on any output.
- R7: Overvoltage in normal operation gives shutdown=1 and force_ls_on=1 on the next clock. These hold until uv_flag is seen. The block then latches shutdown=1 and force_hiz=1, with no automatic restart.
- R8: ot_flag gives shutdown=1 and force_hiz=1 on the next clock, from any state, for as long as it stays high. When it clears, restart_req pulses on the next clock with no hiccup wait.
- R9: When several faults arrive on the same clock, priority from highest to lowest is: overtemperature, low-side overcurrent, overvoltage, high-side count limit, undervoltage.
- R10: A restart clears the overcurrent count and the undervoltage timer. After it, a full set of HS_LIMIT faulty cycles is needed to trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_stb | input | 1 | One-clock strobe at the end of each switching cycle |
| hs_oc | input | 1 | High-side overcurrent flag |
| ls_oc | input | 1 | Low-side overcurrent flag |
| ov_flag | input | 1 | Overvoltage comparator flag |
| uv_flag | input | 1 | Undervoltage comparator flag |
| ot_flag | input | 1 | Overtemperature flag, hysteresis applied outside the block |
| force_ls_on | output | 1 | Override: high side off, low side on |
| force_hiz | output | 1 | Override: both switches off |
| shutdown | output | 1 | Converter is not regulating |
| restart_req | output | 1 | One-cycle request to the soft-start sequencer |

## Verification
The bench builds the block with HICCUP_CYC=20, UV_FILT_CYC=5 and HS_LIMIT=4. With these values a whole hiccup fits in a few dozen clocks, so the bench can count its exact length, see a fault that persists trip a second time, and confirm that the overvoltage latch outlasts a hiccup. The short filter allows checks at one cycle below the undervoltage window and exactly at it. The limit of four lets the count reach three, clear, and reach three again, so the bench can show both the clear on a clean cycle and the clear on restart.

// File: rtl/buck_fault_ctrl.sv
module buck_fault_ctrl #(
  parameter int HICCUP_CYC  = 1450000,
  parameter int UV_FILT_CYC = 1000,
  parameter int HS_LIMIT    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_stb,
  input  logic hs_oc,
  input  logic ls_oc,
  input  logic ov_flag,
  input  logic uv_flag,
  input  logic ot_flag,
  output logic force_ls_on,
  output logic force_hiz,
  output logic shutdown,
  output logic restart_req
);
  localparam int HCW = $clog2(HICCUP_CYC + 1);
  localparam int UVW = $clog2(UV_FILT_CYC + 1);
  localparam int OCW = $clog2(HS_LIMIT + 1);
  localparam logic [HCW-1:0] HC_LAST = HCW'(HICCUP_CYC - 1);
  localparam logic [UVW-1:0] UV_LAST = UVW'(UV_FILT_CYC - 1);
  localparam logic [OCW-1:0] OC_LAST = OCW'(HS_LIMIT - 1);

  typedef enum logic [2:0] {S_RUN, S_OVD, S_HICC, S_LATCH, S_THERM} st_t;

  st_t st, st_n;
  logic           hs_seen;
  logic [OCW-1:0] oc_cnt;
  logic [UVW-1:0] uv_cnt;
  logic [HCW-1:0] hc_cnt;
  logic           restart_q;

  logic run, oc_evt, oc_trip, uv_trip, go_run;
  assign run     = (st == S_RUN);
  assign oc_evt  = run && cyc_stb && (hs_seen || hs_oc);
  assign oc_trip = oc_evt && (oc_cnt == OC_LAST);
  assign uv_trip = run && uv_flag && (uv_cnt == UV_LAST);
  assign go_run  = (st_n == S_RUN) && !run;

  always_comb begin
    st_n = st;
    unique case (st)
      S_RUN: begin
        if (ot_flag)      st_n = S_THERM;
        else if (ls_oc)   st_n = S_HICC;
        else if (ov_flag) st_n = S_OVD;
        else if (oc_trip) st_n = S_HICC;
        else if (uv_trip) st_n = S_HICC;
      end
      S_OVD: begin
        if (ot_flag)      st_n = S_THERM;
        else if (ls_oc)   st_n = S_HICC;
        else if (uv_flag) st_n = S_LATCH;
      end
      S_HICC: begin
        if (ot_flag)                st_n = S_THERM;
        else if (hc_cnt == HC_LAST) st_n = S_RUN;
      end
      S_LATCH: if (ot_flag) st_n = S_THERM;
      S_THERM: if (!ot_flag) st_n = S_RUN;
      default: st_n = S_HICC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_RUN;
      hs_seen   <= 1'b0;
      oc_cnt    <= '0;
      uv_cnt    <= '0;
      hc_cnt    <= '0;
      restart_q <= 1'b0;
    end else begin
      st        <= st_n;
      restart_q <= go_run;
      hs_seen   <= run && !cyc_stb && (hs_seen || hs_oc);
      if (!run)         oc_cnt <= '0;
      else if (cyc_stb) oc_cnt <= oc_evt ? oc_cnt + 1'b1 : '0;
      uv_cnt <= (run && uv_flag) ? uv_cnt + 1'b1 : '0;
      hc_cnt <= (st == S_HICC) ? hc_cnt + 1'b1 : '0;
    end
  end

  logic stage_on;
  assign stage_on    = run || (st == S_OVD);
  assign force_hiz   = (st == S_HICC) || (st == S_LATCH) || (st == S_THERM) || (stage_on && ls_oc);
  assign force_ls_on = !ls_oc && ((st == S_OVD) || (run && (hs_oc || hs_seen)));
  assign shutdown    = !run;
  assign restart_req = restart_q;
endmodule

// File: rtl/buck_fault_ctrl_chk.sv
module buck_fault_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic hs_oc,
  input logic ls_oc,
  input logic ov_flag,
  input logic ot_flag,
  input logic force_ls_on,
  input logic force_hiz,
  input logic shutdown,
  input logic restart_req
);
  p_hs_ls_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!shutdown && hs_oc && !ls_oc) |-> force_ls_on);
  p_ls_comb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!shutdown && ls_oc) |-> (force_hiz && !force_ls_on));
  p_ls_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!shutdown && ls_oc && !ot_flag) |=> (shutdown && force_hiz));
  p_restart_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |=> !restart_req);
  p_restart_after_sd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |-> $past(shutdown));
  p_ov_discharge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!shutdown && ov_flag && !ot_flag && !ls_oc) |=> (shutdown && force_ls_on));
  p_no_conflict_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(force_hiz && force_ls_on));
  p_ot_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ot_flag |=> (shutdown && force_hiz && !force_ls_on));
endmodule

bind buck_fault_ctrl buck_fault_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hs_oc(hs_oc), .ls_oc(ls_oc), .ov_flag(ov_flag),
  .ot_flag(ot_flag), .force_ls_on(force_ls_on), .force_hiz(force_hiz),
  .shutdown(shutdown), .restart_req(restart_req)
);

// File: tb/tb_buck_fault_ctrl.sv
module tb_buck_fault_ctrl;
  localparam int H = 20;
  localparam int U = 5;
  localparam int N = 4;
  localparam logic [5:0] STB = 6'd1, HS = 6'd2, LS = 6'd4, OV = 6'd8, UV = 6'd16, OT = 6'd32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_stb = 0, hs_oc = 0, ls_oc = 0, ov_flag = 0, uv_flag = 0, ot_flag = 0;
  logic force_ls_on, force_hiz, shutdown, restart_req;

  always #5 clk = ~clk;

  buck_fault_ctrl #(.HICCUP_CYC(H), .UV_FILT_CYC(U), .HS_LIMIT(N)) dut (
    .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .hs_oc(hs_oc), .ls_oc(ls_oc),
    .ov_flag(ov_flag), .uv_flag(uv_flag), .ot_flag(ot_flag),
    .force_ls_on(force_ls_on), .force_hiz(force_hiz), .shutdown(shutdown),
    .restart_req(restart_req)
  );

  typedef struct { string tag; logic [3:0] exp; } item_t;
  item_t q[$];
  event smp;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  initial forever begin
    @(smp);
    while (q.size() > 0) begin
      item_t it;
      logic [3:0] got;
      it  = q.pop_front();
      got = {shutdown, force_hiz, force_ls_on, restart_req};
      n_run++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL %s: {sd,hiz,ls_on,rst_req} got %b expected %b", it.tag, got, it.exp);
      end
    end
  end

  task automatic step(input logic [5:0] drv, input string tag, input logic [3:0] exp);
    item_t it;
    @(negedge clk);
    {ot_flag, uv_flag, ov_flag, ls_oc, hs_oc, cyc_stb} = drv;
    it.tag = tag;
    it.exp = exp;
    q.push_back(it);
    #4;
    ->smp;
  endtask

  task automatic sw_cycle(input bit hs, input string tag);
    logic [3:0] e;
    e = {2'b00, hs, 1'b0};
    step(hs ? HS : 6'd0, tag, e);
    step(6'd0, tag, e);
    step(6'd0, tag, e);
    step(STB, tag, e);
  endtask

  task automatic hic_tail(input string tag, input int n);
    for (int i = 0; i < n; i++) step(6'd0, tag, 4'b1100);
    step(6'd0, tag, 4'b0001);
    step(6'd0, tag, 4'b0000);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    item_t it;
    repeat (3) @(negedge clk);
    #4;
    it.tag = "R1 outputs in reset";
    it.exp = 4'b0000;
    q.push_back(it);
    ->smp;
    @(negedge clk);
    rst_n = 1'b1;
    step(6'd0, "R1 idle after reset", 4'b0000);

    repeat (3) sw_cycle(1, "R2 hs oc holds low side to strobe");
    sw_cycle(0, "R3 clean cycle clears count");
    repeat (3) sw_cycle(1, "R3 no trip after clear");
    sw_cycle(0, "R3 clean cycle");

    repeat (N) sw_cycle(1, "R3 counting to limit");
    hic_tail("R3 limit trip then R5 hiccup length", H);

    repeat (3) sw_cycle(1, "R10 partial count");
    step(LS, "R4 low-side trip immediate", 4'b0100);
    hic_tail("R4 hiccup after low-side trip", H);
    repeat (3) sw_cycle(1, "R10 count cleared by restart");
    sw_cycle(0, "R10 clean cycle");

    for (int i = 0; i < U - 1; i++) step(UV, "R6 short uv ignored", 4'b0000);
    step(6'd0, "R6 short uv ignored", 4'b0000);
    for (int i = 0; i < U; i++) step(UV, "R6 uv window", 4'b0000);
    step(UV, "R6 uv trip", 4'b1100);
    for (int i = 0; i < H - 1; i++) step(UV, "R5 hiccup with uv held", 4'b1100);
    step(UV, "R5 restart while uv persists", 4'b0001);
    for (int i = 0; i < U - 1; i++) step(UV, "R5 retry filter", 4'b0000);
    step(6'd0, "R5 persistent fault trips again", 4'b1100);
    hic_tail("R5 second hiccup", H - 1);

    step(OV, "R7 ov registered", 4'b0000);
    for (int i = 0; i < 4; i++) step(6'd0, "R7 low side held on", 4'b1010);
    step(UV, "R7 uv reached", 4'b1010);
    for (int i = 0; i < H + 3; i++) step(6'd0, "R7 latched hiz no restart", 4'b1100);
    step(OT, "R8 ot from latch", 4'b1100);
    step(OT, "R8 ot held", 4'b1100);
    step(6'd0, "R8 ot clears", 4'b1100);
    step(6'd0, "R8 restart on ot clear", 4'b0001);
    step(6'd0, "R8 running", 4'b0000);

    step(OT, "R8 ot from run", 4'b0000);
    for (int i = 0; i < 3; i++) step(OT, "R8 off while ot", 4'b1100);
    step(6'd0, "R8 ot clears", 4'b1100);
    step(6'd0, "R8 restart without hiccup", 4'b0001);
    step(6'd0, "R8 running", 4'b0000);

    step(OT | LS | OV, "R9 all at once", 4'b0100);
    step(OT, "R9 ot wins", 4'b1100);
    step(6'd0, "R9 ot clears", 4'b1100);
    step(6'd0, "R9 restart without hiccup", 4'b0001);
    step(6'd0, "R9 running", 4'b0000);

    step(LS | OV, "R9 ls and ov", 4'b0100);
    hic_tail("R9 ls wins over ov", H);

    repeat (N - 1) sw_cycle(1, "R9 count to limit minus one");
    step(HS, "R9 last hs cycle", 4'b0010);
    step(6'd0, "R9 last hs cycle", 4'b0010);
    step(6'd0, "R9 last hs cycle", 4'b0010);
    step(STB | OV, "R9 ov with limit strobe", 4'b0010);
    step(6'd0, "R9 ov wins over hs limit", 4'b1010);
    step(UV, "R9 discharge ends", 4'b1010);
    step(6'd0, "R9 latched", 4'b1100);
    step(OT, "R9 exit via ot", 4'b1100);
    step(6'd0, "R9 ot clears", 4'b1100);
    step(6'd0, "R9 restart", 4'b0001);
    step(6'd0, "R9 running", 4'b0000);

    @(negedge clk);
    done = 1;
    summary();
  end
endmodule